// File: doc/BRIEF.md
# Banked Per-Core Countdown Timer Array

This block holds one private countdown timer for each processor core of a multi-core cluster. The core count is a parameter, bounded by a fixed maximum. All timers share a single word-wide register bus that is divided into 32-byte windows. Window 0 is a self-alias: each access is steered to the timer of the core whose identifier arrives with it, so every core can run the same driver code at the same address. Window k+1 always reaches the timer of core k, whatever identifier comes with the access. Each timer raises its own interrupt line, and bit k of the interrupt vector belongs to core k.

Inside a window, each timer has four registers. The control register holds enable, auto-reload, interrupt-enable and an 8-bit prescaler. The load register holds the reload value. The count register holds the live count. The status register holds an event flag that is cleared by writing one. The wrapper decodes the address, routes by core identifier, checks the range of that identifier, the access size and the window number, and drives one synchronous reset into every timer. An access that fails any check does not change any timer. It reads as zero and raises a one-cycle error pulse.

Top module: `mpt_bank`

## Requirements
- R1: After reset every timer register reads zero, the interrupt vector is all zero, and the read data and error outputs are zero.
- R2: Window k+1 (byte address 32*(k+1) + offset) reaches core k's timer, whatever the core ID input holds. Register offsets are: 0x0 control, 0x4 load, 0x8 count, 0xC status. Other offsets in a window read zero and ignore writes.
- R3: Window 0 reaches the timer of the core named by the core ID input. Reads and writes there are identical in effect to the same access through that core's direct window.
- R4: The read data output is registered. It changes only in the cycle after a strobe: to the register value for a valid read, and to zero for a write or a rejected access. It holds between strobes.
- R5: An alias access whose core ID is at or above the configured core count changes no timer, reads zero and raises the error output for exactly one cycle.
- R6: An access with a size code other than 2 (32-bit), a nonzero address in bits [1:0], or a window number above the core count is rejected in the same way as in R5. A valid access leaves the error output low.
- R7: Control bit 0 enables counting, and bits [15:8] hold a prescale value P. An enabled timer decrements a nonzero count once every P+1 cycles. Writing the load register sets both load and count.
- R8: When a count of 1 is decremented, status bit 0 is set. With control bit 1 set, the count reloads from the load register. With bit 1 clear, it stops at 0 and stays there.
- R9: Status bit 0 is cleared only by a status write with data bit 0 set. Interrupt k equals core k's status bit AND its control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, fanned out to all timers |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code; only 2 (32-bit) is accepted |
| bus_core_id | input | CID_W | ID of the issuing core, used by window 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a rejected access |
| irq | output | NUM_CORES | Per-core interrupt, bit k for core k |

## Verification
The hardest situation to reach from the ports is showing that the alias window and the direct windows reach the same physical timer, and never a neighbour. The bench writes a distinct value into every core through its direct window while the core ID input holds an out-of-range value. It then reads each value back through the alias under every legal ID, and writes through the alias again and reads through the direct windows. The prescaler rate is measured by two count reads placed exactly 40 cycles apart, which gives a whole number of ticks for any phase. Interrupt-line ownership is checked with the whole vector while timers in different modes run side by side.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int DATA_W   = 32;
  localparam int WIN_LSB  = 5;            // 32-byte windows
  localparam int CTL_EN   = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_IEN  = 2;
  localparam int PRE_LSB  = 8;
  localparam int PRE_W    = 8;
  localparam logic [15:0] CTRL_MASK = 16'hFF07;
  localparam logic [1:0]  SZ_WORD   = 2'd2;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_LOAD  = 3'd1,
    REG_COUNT = 3'd2,
    REG_STAT  = 3'd3
  } reg_e;
endpackage

// File: rtl/mpt_decode.sv
module mpt_decode
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int CID_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CID_W-1:0]  core_id,
  output logic              ok,
  output logic [CID_W-1:0]  tgt,
  output logic [2:0]        reg_idx
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] win;
  logic             is_alias;
  logic             id_ok;
  logic             win_ok;

  always_comb begin
    win      = addr[ADDR_W-1:WIN_LSB];
    is_alias = (win == '0);
    id_ok    = (int'(core_id) < NUM_CORES);
    win_ok   = (int'(win) <= NUM_CORES);
    tgt      = is_alias ? core_id : CID_W'(win - 1'b1);
    reg_idx  = addr[4:2];
    ok       = (size == SZ_WORD) && (addr[1:0] == 2'b00) &&
               (is_alias ? id_ok : win_ok);
  end
endmodule

// File: rtl/mpt_timer.sv
module mpt_timer
  import mpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              irq
);
  logic [15:0]       ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cnt_q;
  logic              stat_q;
  logic [PRE_W-1:0]  pre_q;
  logic              tick;

  always_comb tick = ctrl_q[CTL_EN] && (pre_q == ctrl_q[PRE_LSB +: PRE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      stat_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      if (ctrl_q[CTL_EN]) pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && cnt_q != '0) begin
        if (cnt_q == DATA_W'(1)) begin
          stat_q <= 1'b1;
          cnt_q  <= ctrl_q[CTL_AUTO] ? load_q : '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      // bus writes take priority over the counting update
      if (wr_en) begin
        case (reg_e'(reg_idx))
          REG_CTRL:  begin ctrl_q <= wdata[15:0] & CTRL_MASK; pre_q <= '0; end
          REG_LOAD:  begin load_q <= wdata; cnt_q <= wdata; end
          REG_COUNT: cnt_q <= wdata;
          REG_STAT:  if (wdata[0]) stat_q <= 1'b0;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_e'(reg_idx))
      REG_CTRL:  rd_val = {16'b0, ctrl_q};
      REG_LOAD:  rd_val = load_q;
      REG_COUNT: rd_val = cnt_q;
      REG_STAT:  rd_val = {31'b0, stat_q};
      default:   rd_val = '0;
    endcase
  end

  assign irq = stat_q & ctrl_q[CTL_IEN];

  // R9
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !(wr_en && reg_idx == REG_STAT && wdata[0])) |=> stat_q);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cnt_q > DATA_W'(1)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DATA_W'(1)));

  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/mpt_bank.sv
module mpt_bank
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_CORES = 8,
  parameter int ADDR_W    = 8,
  parameter int CID_W     = $clog2(MAX_CORES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [CID_W-1:0]     bus_core_id,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic [NUM_CORES-1:0] irq
);
  logic                 acc_ok;
  logic [CID_W-1:0]     tgt;
  logic [2:0]           reg_idx;
  logic [NUM_CORES-1:0] wr_vec;
  logic [DATA_W-1:0]    rd_vals [NUM_CORES];
  logic [DATA_W-1:0]    rd_sel;

  mpt_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CID_W(CID_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .core_id(bus_core_id),
    .ok(acc_ok), .tgt(tgt), .reg_idx(reg_idx)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    assign wr_vec[k] = bus_valid && bus_we && acc_ok && (tgt == CID_W'(k));
    mpt_timer u_tmr (
      .clk(clk), .rst(rst), .wr_en(wr_vec[k]), .reg_idx(reg_idx),
      .wdata(bus_wdata), .rd_val(rd_vals[k]), .irq(irq[k])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NUM_CORES; k++)
      if (tgt == CID_W'(k)) rd_sel = rd_vals[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bus_valid && !acc_ok;
      if (bus_valid) bus_rdata <= (acc_ok && !bus_we) ? rd_sel : '0;
    end
  end

  // R5
  alias_block_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr[ADDR_W-1:WIN_LSB] == '0 &&
     int'(bus_core_id) >= NUM_CORES) |-> wr_vec == '0);

  // R6
  reject_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !acc_ok) |=> (bus_err && bus_rdata == '0));

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> $stable(bus_rdata));
endmodule

// File: tb/mpt_bank_tb.sv
module mpt_bank_tb;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [2:0]  bus_core_id = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mpt_bank #(.NUM_CORES(NC)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_core_id(bus_core_id),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [2:0] cid,
                     input logic [31:0] wd, input logic [1:0] sz,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_core_id = cid;
    bus_wdata = wd; bus_size = sz;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] cid, input logic [31:0] wd);
    logic [31:0] d; logic e;
    acc(1'b1, a, cid, wd, 2'd2, d, e);
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] cid, output logic [31:0] d);
    logic e;
    acc(1'b0, a, cid, 32'h0, 2'd2, d, e);
  endtask

  function automatic logic [7:0] dwin(input int core, input int off);
    return 8'((core + 1) * 32 + off);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 err", 32'(bus_err), 32'h0);
    for (int w = 0; w <= NC; w++)
      for (int o = 0; o < 4; o++) begin
        rd(8'(w * 32 + o * 4), 3'd0, d);
        chk("R1 reg zero", d, 32'h0);
      end

    // R2 direct writes with an out-of-range ID present; R3 alias reads
    for (int k = 0; k < NC; k++) wr(dwin(k, 4), 3'd7, 32'h100 + 32'(k * 17));
    for (int k = 0; k < NC; k++) begin
      rd(dwin(k, 4), 3'd7, d);
      chk("R2 direct load", d, 32'h100 + 32'(k * 17));
      rd(8'h04, 3'(k), d);
      chk("R3 alias load", d, 32'h100 + 32'(k * 17));
      rd(dwin(k, 8), 3'd0, d);
      chk("R7 load sets count", d, 32'h100 + 32'(k * 17));
    end
    for (int k = 0; k < NC; k++) wr(8'h08, 3'(k), 32'h5000 + 32'(k));
    for (int k = 0; k < NC; k++) begin
      rd(dwin(k, 8), 3'd0, d);
      chk("R3 alias write", d, 32'h5000 + 32'(k));
    end
    wr(dwin(1, 16), 3'd0, 32'hFFFF_FFFF);
    rd(dwin(1, 16), 3'd0, d);
    chk("R2 unused offset", d, 32'h0);
    rd(dwin(1, 4), 3'd0, d);
    chk("R2 unused offset no side effect", d, 32'h111);

    // R4 registered read holds
    rd(dwin(2, 4), 3'd0, d);
    @(negedge clk);
    chk("R4 hold", bus_rdata, d);
    wr(dwin(2, 12), 3'd0, 32'h0);
    chk("R4 write gives zero", bus_rdata, 32'h0);

    // R5 out-of-range alias IDs
    for (int c = NC; c < 8; c++) begin
      acc(1'b1, 8'h04, 3'(c), 32'hDEAD_BEEF, 2'd2, d, e);
      chk("R5 write err", 32'(e), 32'h1);
      acc(1'b0, 8'h04, 3'(c), 32'h0, 2'd2, d, e);
      chk("R5 read err", 32'(e), 32'h1);
      chk("R5 read zero", d, 32'h0);
      @(negedge clk);
      chk("R5 err single cycle", 32'(bus_err), 32'h0);
    end
    for (int k = 0; k < NC; k++) begin
      rd(dwin(k, 4), 3'd0, d);
      chk("R5 loads untouched", d, 32'h100 + 32'(k * 17));
    end

    // R6 size, alignment, window range
    acc(1'b1, dwin(0, 4), 3'd0, 32'h77, 2'd1, d, e);
    chk("R6 size err", 32'(e), 32'h1);
    acc(1'b1, 8'h25, 3'd0, 32'h77, 2'd2, d, e);
    chk("R6 misaligned err", 32'(e), 32'h1);
    acc(1'b0, dwin(NC, 4), 3'd0, 32'h0, 2'd2, d, e);
    chk("R6 window err", 32'(e), 32'h1);
    chk("R6 window zero", d, 32'h0);
    acc(1'b0, dwin(0, 4), 3'd0, 32'h0, 2'd2, d, e);
    chk("R6 valid no err", 32'(e), 32'h0);
    chk("R6 load untouched", d, 32'h100);

    // R7 prescaled rate: 40 cycles apart
    wr(dwin(0, 4), 3'd0, 32'd1000);
    wr(dwin(0, 0), 3'd0, 32'h0000_0301);
    rd(dwin(0, 8), 3'd0, d);
    repeat (38) @(negedge clk);
    rd(dwin(0, 8), 3'd0, d2);
    chk("R7 prescale 3 rate", d - d2, 32'd10);
    wr(dwin(0, 0), 3'd0, 32'h0);
    wr(dwin(3, 4), 3'd0, 32'd1000);
    wr(dwin(3, 0), 3'd0, 32'h1);
    rd(dwin(3, 8), 3'd0, d);
    repeat (38) @(negedge clk);
    rd(dwin(3, 8), 3'd0, d2);
    chk("R7 prescale 0 rate", d - d2, 32'd40);
    wr(dwin(3, 0), 3'd0, 32'h0);

    // R8 one-shot
    wr(dwin(1, 4), 3'd0, 32'd10);
    wr(dwin(1, 0), 3'd0, 32'h5);
    repeat (30) @(negedge clk);
    rd(dwin(1, 8), 3'd0, d);
    chk("R8 one-shot stops at 0", d, 32'h0);
    rd(dwin(1, 12), 3'd0, d);
    chk("R8 one-shot status", d, 32'h1);
    chk("R9 irq1", 32'(irq[1]), 32'h1);

    // R8 periodic
    wr(dwin(2, 4), 3'd0, 32'd5);
    wr(dwin(2, 0), 3'd0, 32'h7);
    repeat (20) @(negedge clk);
    rd(dwin(2, 8), 3'd0, d);
    chk("R8 periodic reloads", 32'((d != 0) && (d <= 5)), 32'h1);
    wr(dwin(2, 0), 3'd0, 32'h6);
    rd(dwin(2, 12), 3'd0, d);
    chk("R8 periodic status", d, 32'h1);

    // R9 write-one-to-clear
    wr(dwin(2, 12), 3'd0, 32'hFFFF_FFFE);
    rd(dwin(2, 12), 3'd0, d);
    chk("R9 write zero keeps", d, 32'h1);
    wr(8'h0C, 3'd2, 32'h1);
    rd(dwin(2, 12), 3'd0, d);
    chk("R9 clear", d, 32'h0);
    chk("R9 irq2 low", 32'(irq[2]), 32'h0);
    wr(dwin(2, 0), 3'd0, 32'h7);
    repeat (20) @(negedge clk);
    rd(dwin(2, 12), 3'd0, d);
    chk("R8 periodic repeats", d, 32'h1);

    // R9 interrupt enable gating
    wr(dwin(3, 4), 3'd0, 32'd3);
    wr(dwin(3, 0), 3'd0, 32'h1);
    repeat (10) @(negedge clk);
    rd(dwin(3, 12), 3'd0, d);
    chk("R9 status without ien", d, 32'h1);
    chk("R9 irq vector", 32'(irq), 32'h6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule